// File: doc/BRIEF.md
# Timer Global Control Unit

This unit holds the configuration that applies to a whole multi-channel timer. It has a small register port for writing and reading three registers: a control word, an output-disable mask and a channel-disable mask. From these it drives the shared signals that the timer channels and the time-base client use: a channel clock-enable, a prescaled tick, a global time-base enable output, a freeze qualifier for each channel, a counter-bus source select and a server-slot number.

The prescaler divides by the programmed value plus one. While it is switched off, it holds its counter at zero, so the first period after it starts is always full. A new divide value written during a run takes effect only at the next wrap, which keeps every period whole. A channel freezes only when three conditions hold together: the freeze bit is set, debug mode is active and that channel's freeze-enable bit is set. The module-off bit stops the prescaler and drops the channel clock-enable. The register port keeps working while the module is off.

Top module: `tmr_gctl_top`

## Requirements
- R1: The control word holds the divide value in bits 23:16. A value of D makes `pre_tick` a one-cycle pulse once every D+1 advancing cycles. After a fresh start, the first pulse comes in the (D+1)th advancing cycle that follows the write cycle. D=0 gives a pulse on every advancing cycle.
- R2: While the run bit (bit 4) is 0, `pre_tick` stays low and the count is cleared. When the run bit is set again, counting restarts from zero, even if the prescaler was stopped partway through a period.
- R3: While the off bit (bit 0) is 1, `chan_clk_en` is low and the prescaler neither ticks nor counts. The control register (address 0), the output-disable register (address 1) and the channel-disable register (address 2) can still be written and read in this state.
- R4: `gtb_out` follows the control bit at position 2.
- R5: While `gtb_in` is low, the prescaler holds its count and gives no tick. When `gtb_in` returns high, counting continues from the held count.
- R6: `chan_frozen[i]` is 1 only when all three hold: the freeze bit (bit 1) is 1, `dbg_mode` is 1 and `frz_en[i]` is 1.
- R7: A frozen channel leaves the frozen state in the same cycle that any one of these happens: the freeze bit is written to 0, `dbg_mode` falls, or its `frz_en` bit clears.
- R8: `busa_ext_sel` follows control bit 3, where 1 selects the external client and 0 selects the designated channel. `srv_slot` follows control bits 11:8.
- R9: A divide value written while the prescaler runs takes effect at the next wrap. The period in progress finishes with the old value.
- R10: After reset, all three registers read as zero. `chan_clk_en` is 1, and `gtb_out`, `pre_tick` and every `chan_frozen` bit are 0.
- R11: A read from address 3 returns zero. Reads are combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| dbg_mode | input | 1 | Debug mode is active |
| gtb_in | input | 1 | Global time-base enable input |
| frz_en | input | 8 | Freeze-enable bit for each channel |
| chan_clk_en | output | 1 | Clock-enable for the channels |
| pre_tick | output | 1 | Prescaled tick pulse |
| gtb_out | output | 1 | Global time-base enable output |
| chan_frozen | output | 8 | Freeze qualifier for each channel |
| busa_ext_sel | output | 1 | Counter bus A source: 1 selects the external client |
| srv_slot | output | 4 | Server slot passed to the client |
| out_dis | output | 8 | Output-disable mask |
| chan_off | output | 8 | Channel-disable mask |

## Verification
The bench uses the default parameters: 32-bit data, eight channels, an 8-bit divide field and a 4-bit slot field. These values let it run divide ratios of 1, 4 and 7 over several full periods each. It also changes the divide value in the middle of a run, and it stops the prescaler partway through a period and restarts it. Eight channels give enough freeze-enable patterns to test each of the three freeze exit conditions on its own.

// File: rtl/tmr_gctl_pkg.sv
// Shared constants for the timer global control unit: the register
// addresses and the bit positions inside the control word.
package tmr_gctl_pkg;
    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_ODIS = 2'd1,
        RA_CDIS = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    localparam int B_OFF    = 0;
    localparam int B_FRZ    = 1;
    localparam int B_GTBO   = 2;
    localparam int B_EXT    = 3;
    localparam int B_RUN    = 4;
    localparam int SLOT_LSB = 8;
    localparam int DIV_LSB  = 16;
endpackage

// File: rtl/tmr_gctl_regs.sv
// Register file for the control word and the two channel masks.
// Writes are taken on any clock edge where reg_we is high; the off bit
// does not block writes. Reads are a combinational mux.
// Assumes NCH <= DATA_W and DIV_LSB + DIV_W <= DATA_W.
module tmr_gctl_regs
    import tmr_gctl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NCH    = 8,
    parameter int SLOT_W = 4,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              off_q,
    output logic              frz_q,
    output logic              gtbo_q,
    output logic              ext_q,
    output logic              run_q,
    output logic [SLOT_W-1:0] slot_q,
    output logic [DIV_W-1:0]  div_q,
    output logic [DIV_W-1:0]  div_next,
    output logic [NCH-1:0]    odis_q,
    output logic [NCH-1:0]    cdis_q
);
    localparam int MASK_PAD = DATA_W - NCH;

    logic ctrl_wr;
    logic [DATA_W-1:0] ctrl_rd;

    assign ctrl_wr  = we && (addr == RA_CTRL);
    // The divide value as it will stand after this edge
    assign div_next = ctrl_wr ? wdata[DIV_LSB +: DIV_W] : div_q;

    // Control word storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q  <= 1'b0;
            frz_q  <= 1'b0;
            gtbo_q <= 1'b0;
            ext_q  <= 1'b0;
            run_q  <= 1'b0;
            slot_q <= '0;
            div_q  <= '0;
        end else if (ctrl_wr) begin
            off_q  <= wdata[B_OFF];
            frz_q  <= wdata[B_FRZ];
            gtbo_q <= wdata[B_GTBO];
            ext_q  <= wdata[B_EXT];
            run_q  <= wdata[B_RUN];
            slot_q <= wdata[SLOT_LSB +: SLOT_W];
            div_q  <= wdata[DIV_LSB +: DIV_W];
        end
    end

    // Output-disable and channel-disable masks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odis_q <= '0;
            cdis_q <= '0;
        end else if (we) begin
            if (addr == RA_ODIS) odis_q <= wdata[NCH-1:0];
            if (addr == RA_CDIS) cdis_q <= wdata[NCH-1:0];
        end
    end

    // Assemble the control word for read-back
    always_comb begin
        ctrl_rd                        = '0;
        ctrl_rd[B_OFF]                 = off_q;
        ctrl_rd[B_FRZ]                 = frz_q;
        ctrl_rd[B_GTBO]                = gtbo_q;
        ctrl_rd[B_EXT]                 = ext_q;
        ctrl_rd[B_RUN]                 = run_q;
        ctrl_rd[SLOT_LSB +: SLOT_W]    = slot_q;
        ctrl_rd[DIV_LSB +: DIV_W]      = div_q;
    end

    // Read data mux
    always_comb begin
        case (addr)
            RA_CTRL: rdata = ctrl_rd;
            RA_ODIS: rdata = {{MASK_PAD{1'b0}}, odis_q};
            RA_CDIS: rdata = {{MASK_PAD{1'b0}}, cdis_q};
            default: rdata = '0;
        endcase
    end

    AST_CTRL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (div_q == $past(wdata[DIV_LSB +: DIV_W])) && (off_q == $past(wdata[B_OFF]))); // R3
    AST_ODIS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == RA_ODIS) |=> (odis_q == $past(wdata[NCH-1:0]))); // R3
endmodule

// File: rtl/tmr_gctl_presc.sv
// Global prescaler. It counts advancing cycles (run && gate) up to the
// active divide value, pulses tick on the wrap cycle and loads the pending
// divide value only at a wrap or while stopped. Assumes div_next already
// reflects a write made in the same cycle.
module tmr_gctl_presc #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             gate,
    input  logic [DIV_W-1:0] div_next,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_act;
    logic             adv;
    logic             wrap;

    assign adv  = run && gate;
    assign wrap = (cnt == div_act);
    assign tick = adv && wrap;

    // Count, wrap and take the new divide value at a period boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            div_act <= '0;
        end else if (!run) begin
            cnt     <= '0;
            div_act <= div_next;
        end else if (gate) begin
            if (wrap) begin
                cnt     <= '0;
                div_act <= div_next;
            end else begin
                cnt     <= cnt + 1'b1;
            end
        end
    end

    AST_CNT_BOUND:  assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= div_act); // R1
    AST_WRAP_ZERO:  assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == '0)); // R1
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0)); // R2
    AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !gate) |=> (cnt == $past(cnt))); // R5
endmodule

// File: rtl/tmr_gctl_frz.sv
// Per-channel freeze qualifier. A channel is frozen while the global
// freeze bit, debug mode and its own enable are all high; leaving happens
// combinationally as soon as any of the three drops.
module tmr_gctl_frz #(
    parameter int NCH = 8
) (
    input  logic           frz,
    input  logic           dbg,
    input  logic [NCH-1:0] fen,
    output logic [NCH-1:0] frozen
);
    // One qualifier per channel
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign frozen[g] = frz && dbg && fen[g];
    end
endmodule

// File: rtl/tmr_gctl_top.sv
// Timer global control unit: register port, prescaler, freeze qualifiers
// and the module-wide selects. The off bit stops functional counting and
// drops the channel clock-enable but leaves the register port working.
module tmr_gctl_top
    import tmr_gctl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NCH    = 8,
    parameter int SLOT_W = 4,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dbg_mode,
    input  logic              gtb_in,
    input  logic [NCH-1:0]    frz_en,
    output logic              chan_clk_en,
    output logic              pre_tick,
    output logic              gtb_out,
    output logic [NCH-1:0]    chan_frozen,
    output logic              busa_ext_sel,
    output logic [SLOT_W-1:0] srv_slot,
    output logic [NCH-1:0]    out_dis,
    output logic [NCH-1:0]    chan_off
);
    logic              off_q, frz_q, gtbo_q, ext_q, run_q;
    logic [SLOT_W-1:0] slot_q;
    logic [DIV_W-1:0]  div_q, div_next;

    tmr_gctl_regs #(.DATA_W(DATA_W), .NCH(NCH), .SLOT_W(SLOT_W), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .off_q(off_q), .frz_q(frz_q), .gtbo_q(gtbo_q),
        .ext_q(ext_q), .run_q(run_q), .slot_q(slot_q), .div_q(div_q),
        .div_next(div_next), .odis_q(out_dis), .cdis_q(chan_off)
    );

    tmr_gctl_presc #(.DIV_W(DIV_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run_q), .gate(!off_q && gtb_in),
        .div_next(div_next), .tick(pre_tick)
    );

    tmr_gctl_frz #(.NCH(NCH)) u_frz (
        .frz(frz_q), .dbg(dbg_mode), .fen(frz_en), .frozen(chan_frozen)
    );

    assign chan_clk_en  = !off_q;
    assign gtb_out      = gtbo_q;
    assign busa_ext_sel = ext_q;
    assign srv_slot     = slot_q;

    AST_FRZ_NO_DBG:   assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_mode |-> (chan_frozen == '0)); // R7
    AST_FRZ_SUBSET:   assert property (@(posedge clk) disable iff (!rst_n)
        ((chan_frozen & ~frz_en) == '0)); // R6
    AST_OFF_NO_TICK:  assert property (@(posedge clk) disable iff (!rst_n)
        !chan_clk_en |-> !pre_tick); // R3
    AST_GTB_NO_TICK:  assert property (@(posedge clk) disable iff (!rst_n)
        !gtb_in |-> !pre_tick); // R5
endmodule

// File: tb/tmr_gctl_top_test.sv
// Scoreboard bench: the driver pushes expected tick values, the monitor
// pops and compares them a little after each falling edge.
module tmr_gctl_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dbg_mode = 1'b0;
    logic        gtb_in = 1'b1;
    logic [NCH-1:0] frz_en = '0;
    logic        chan_clk_en, pre_tick, gtb_out, busa_ext_sel;
    logic [NCH-1:0] chan_frozen, out_dis, chan_off;
    logic [3:0]  srv_slot;

    int checks = 0;
    int fails  = 0;
    bit exp_q[$];
    string tag_q[$];

    tmr_gctl_top uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbg_mode(dbg_mode),
        .gtb_in(gtb_in), .frz_en(frz_en), .chan_clk_en(chan_clk_en),
        .pre_tick(pre_tick), .gtb_out(gtb_out), .chan_frozen(chan_frozen),
        .busa_ext_sel(busa_ext_sel), .srv_slot(srv_slot), .out_dis(out_dis),
        .chan_off(chan_off)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mk(bit off, bit frz, bit gtbo, bit ext, bit run,
                                       logic [3:0] slot, logic [7:0] dv);
        logic [31:0] w = '0;
        w[0] = off; w[1] = frz; w[2] = gtbo; w[3] = ext; w[4] = run;
        w[11:8] = slot; w[23:16] = dv;
        return w;
    endfunction

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic wr(logic [1:0] a, logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(string rq, logic [1:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(rq, reg_rdata, exp);
    endtask

    // Driver: one expected tick value per cycle
    task automatic expect_ticks(string rq, int n, int first, int period);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back((k >= first) && (((k - first) % period) == 0));
            tag_q.push_back(rq);
            @(negedge clk);
        end
    endtask

    // Monitor: compare the tick output against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                bit e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (pre_tick !== e) begin
                    fails++;
                    $display("FAIL %s pre_tick act=%0b exp=%0b", t, pre_tick, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog act=running exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state
        rd_chk("R10 ctrl", 2'd0, 32'h0);
        rd_chk("R10 odis", 2'd1, 32'h0);
        rd_chk("R10 cdis", 2'd2, 32'h0);
        chk("R10 clk_en", chan_clk_en, 1);
        chk("R10 gtb_out", gtb_out, 0);
        chk("R10 tick", pre_tick, 0);
        chk("R10 frozen", chan_frozen, 0);
        @(negedge clk);

        // R1: several divide ratios from a fresh start
        wr(2'd0, mk(0,0,0,0,1,0,8'd0)); expect_ticks("R1 div1", 5, 0, 1);
        wr(2'd0, mk(0,0,0,0,0,0,8'd0));
        wr(2'd0, mk(0,0,0,0,1,0,8'd3)); expect_ticks("R1 div4", 13, 3, 4);
        wr(2'd0, mk(0,0,0,0,0,0,8'd0));
        wr(2'd0, mk(0,0,0,0,1,0,8'd6)); expect_ticks("R1 div7", 22, 6, 7);
        wr(2'd0, mk(0,0,0,0,0,0,8'd0));

        // R2: stop mid-period, no ticks, restart from zero
        wr(2'd0, mk(0,0,0,0,1,0,8'd3)); expect_ticks("R2 pre", 2, 3, 4);
        wr(2'd0, mk(0,0,0,0,0,0,8'd3));
        expect_ticks("R2 stopped", 3, 1000, 1);
        wr(2'd0, mk(0,0,0,0,1,0,8'd3)); expect_ticks("R2 restart", 8, 3, 4);
        wr(2'd0, mk(0,0,0,0,0,0,8'd0));

        // R9: divide change mid-run applies at next wrap
        wr(2'd0, mk(0,0,0,0,1,0,8'd1)); expect_ticks("R9 old", 2, 1, 2);
        wr(2'd0, mk(0,0,0,0,1,0,8'd3)); expect_ticks("R9 new", 9, 0, 4);
        wr(2'd0, mk(0,0,0,0,0,0,8'd0));

        // R5: time-base input low holds the count
        gtb_in = 1'b0;
        wr(2'd0, mk(0,0,0,0,1,0,8'd2)); expect_ticks("R5 held", 4, 1000, 1);
        gtb_in = 1'b1; expect_ticks("R5 resume", 6, 2, 3);
        wr(2'd0, mk(0,0,0,0,0,0,8'd0));

        // R3: module off stops counting, registers stay accessible
        wr(2'd0, mk(1,0,0,0,1,0,8'd0));
        chk("R3 clk_en off", chan_clk_en, 0);
        expect_ticks("R3 no tick", 3, 1000, 1);
        wr(2'd1, 32'h0000_00A5);
        wr(2'd2, 32'h0000_003C);
        rd_chk("R3 odis rd", 2'd1, 32'h0000_00A5);
        rd_chk("R3 cdis rd", 2'd2, 32'h0000_003C);
        rd_chk("R3 ctrl rd", 2'd0, mk(1,0,0,0,1,0,8'd0));
        chk("R3 out_dis", out_dis, 8'hA5);
        chk("R3 chan_off", chan_off, 8'h3C);
        @(negedge clk);
        wr(2'd0, mk(0,0,0,0,1,0,8'd0));
        chk("R3 clk_en on", chan_clk_en, 1);
        expect_ticks("R3 resume", 3, 0, 1);
        wr(2'd0, mk(0,0,0,0,0,0,8'd0));

        // R6 / R7: freeze qualifier and its exits
        wr(2'd0, mk(0,1,0,0,0,0,8'd0));
        dbg_mode = 1'b1; frz_en = 8'h05; #1;
        chk("R6 frozen", chan_frozen, 8'h05);
        dbg_mode = 1'b0; #1;
        chk("R7 dbg exit", chan_frozen, 8'h00);
        dbg_mode = 1'b1; frz_en = 8'h04; #1;
        chk("R7 fen exit", chan_frozen, 8'h04);
        @(negedge clk);
        wr(2'd0, mk(0,0,0,0,0,0,8'd0));
        chk("R7 frz exit", chan_frozen, 8'h00);
        dbg_mode = 1'b0; frz_en = 8'hFF;
        wr(2'd0, mk(0,1,0,0,0,0,8'd0));
        chk("R6 no dbg", chan_frozen, 8'h00);

        // R4 / R8: pass-through bits
        wr(2'd0, mk(0,0,1,1,0,4'hA,8'd0));
        chk("R4 gtb_out", gtb_out, 1);
        chk("R8 ext sel", busa_ext_sel, 1);
        chk("R8 slot", srv_slot, 4'hA);
        wr(2'd0, mk(0,0,0,0,0,4'h5,8'd0));
        chk("R4 gtb_out low", gtb_out, 0);
        chk("R8 ext clr", busa_ext_sel, 0);
        chk("R8 slot2", srv_slot, 4'h5);

        // R11: unmapped address
        rd_chk("R11 unmapped", 2'd3, 32'h0);

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule